// File: doc/BRIEF.md
# Serial EEPROM Write-Path Target

This block is the receive side of a two-wire serial memory target. A bus master sends a START, a device byte, two word-address bytes and then any number of data bytes. The block samples SCL and SDA with the system clock and finds the START, STOP and clock edges itself. It answers each accepted byte by pulling SDA low for one bit time and never drives SDA high. Data bytes go into a one-page staging buffer. Within that page, a six-bit offset counter advances after each byte and wraps from the last location back to the first. The page number never changes during a transaction.

A STOP that follows at least one data byte starts a timed write cycle. For the whole cycle the block ignores the bus. When the cycle ends, the staged bytes are copied into the register-held array in one step, and only the locations that were actually received are updated. A two-bit protection mode input marks part of the array as read-only. A write aimed into that part is refused at the low word-address byte. A START that arrives before the STOP throws away everything staged so far. Surrounding logic reads the array through a combinational read port.

Top module: `eewr_target`

## Requirements
- R1: The device byte is acknowledged only when its upper seven bits equal parameter DEV_ADDR and its least significant bit is 0. Otherwise no acknowledge is given, and no later byte of that transaction is acknowledged or stored.
- R2: Two word-address bytes follow the device byte, high byte first, and each one is acknowledged. The word address is the low ADDR_W bits of {high, low}, so higher bits of the high byte are ignored.
- R3: Each data byte is acknowledged and staged at page base plus offset. The offset starts at word-address bits [5:0] and goes up by one per byte, modulo 64. Bits [ADDR_W-1:6] stay fixed, so a 12-byte write starting at offset 60 fills offsets 60..63 and then 0..7.
- R4: When more than 64 data bytes are sent, each later byte replaces the byte staged earlier at the same offset. Only the last value for each offset is written.
- R5: The array does not change until the write cycle that a STOP starts has ended. Then exactly the offsets received in that transaction take their staged values, and all other locations keep their contents.
- R6: busy goes high two cycles after the STOP is detected and stays high for WR_CYCLES cycles. While busy is high, sda_oe stays 0 and even a matching device byte gets no acknowledge.
- R7: prot_mode selects the read-only region. 0 means none, 1 means addresses whose top two bits are 11, 2 means addresses whose top bit is 1, and 3 means the whole array. A word address inside the region is not acknowledged at its low byte, later data bytes are not acknowledged, and nothing is written or started.
- R8: A START or repeated START before the STOP drops all staged data, so no write cycle results from it. The new START is decoded as the beginning of a fresh transaction.
- R9: After reset, sda_oe is 0, busy is 0 and every array location reads 0. sda_oe changes only while SCL is low.
- R10: A STOP that follows a transaction with no data byte starts no write cycle and changes no array location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| prot_mode | input | 2 | Read-only region select (see R7) |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array contents at rd_addr |
| busy | output | 1 | Internal write cycle in progress |

## Verification
On every cycle, the assertions check that busy lasts exactly WR_CYCLES cycles and starts only after a STOP. They also check that the data line is released for the whole write cycle, that the acknowledge driver changes only while SCL is low, and that the array is stable except in the cycle right after a commit. The placement of bytes cannot be checked that way: the page wrap at offset 63, overwriting after more than 64 bytes, refusal of protected addresses, and the discarding of staged data on an early START. The bench shows these by comparing the whole array with its own model after each transaction.

// File: rtl/eewr_pkg.sv
// Package: shared types for the serial EEPROM write-path target.
// Assumes: nothing beyond the standard language.
package eewr_pkg;
    // Transaction phase of the byte decoder
    typedef enum logic [2:0] {
        PH_IDLE,   // waiting for START
        PH_DEV,    // receiving the device byte
        PH_AHI,    // receiving the high word-address byte
        PH_ALO,    // receiving the low word-address byte
        PH_DATA,   // receiving data bytes
        PH_SKIP    // transaction refused, wait for START or STOP
    } phase_t;
endpackage

// File: rtl/eewr_bus_sync.sv
// Module: eewr_bus_sync
// Brings SCL and SDA into the clock domain and produces single-cycle
// events for SCL rising, SCL falling, START and STOP.
// Assumes: SYNC_STAGES >= 2 and each bus phase lasts several clocks.
module eewr_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [SYNC_STAGES-1:0] scl_ff;
    logic [SYNC_STAGES-1:0] sda_ff;
    logic scl_s, scl_d, sda_d;

    // Synchronizer chains, idle high after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
            scl_d  <= scl_s;
            sda_d  <= sda_s;
        end
    end

    assign scl_s = scl_ff[SYNC_STAGES-1];
    assign sda_s = sda_ff[SYNC_STAGES-1];

    // Edge and bus-condition decode
    always_comb begin
        scl_rise  = scl_s && !scl_d;
        scl_fall  = !scl_s && scl_d;
        start_evt = scl_s && scl_d && sda_d && !sda_s;
        stop_evt  = scl_s && scl_d && !sda_d && sda_s;
    end
endmodule

// File: rtl/eewr_proto.sv
// Module: eewr_proto
// Byte-level decoder for the write transaction: device byte, two
// word-address bytes, then data bytes staged by in-page offset.
// Drives the acknowledge and requests a commit on STOP.
// Assumes: 8 < ADDR_W <= 16 and ADDR_W - 2 >= OFF_W (protection
// regions are whole pages).
module eewr_proto
    import eewr_pkg::*;
#(
    parameter int          ADDR_W   = 9,
    parameter int          OFF_W    = 6,
    parameter logic [6:0]  DEV_ADDR = 7'h50
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    busy,
    input  logic                    sda_s,
    input  logic                    scl_rise,
    input  logic                    scl_fall,
    input  logic                    start_evt,
    input  logic                    stop_evt,
    input  logic [1:0]              prot_mode,
    output logic                    sda_oe,
    output logic                    buf_we,
    output logic [OFF_W-1:0]        buf_off,
    output logic [7:0]              buf_data,
    output logic                    buf_clr,
    output logic [ADDR_W-OFF_W-1:0] page_idx,
    output logic                    commit_req
);
    localparam int HI_W = ADDR_W - 8;
    localparam int PG_W = ADDR_W - OFF_W;

    phase_t            ph;
    logic [7:0]        shreg;
    logic [3:0]        bitcnt;
    logic              in_ack;
    logic              ack_drv;
    logic [HI_W-1:0]   ahi;
    logic [OFF_W-1:0]  off;
    logic              got_data;
    logic [ADDR_W-1:0] waddr;
    logic              prot_hit;

    // Word address formed from stored high byte and just-received low byte
    assign waddr = {ahi, shreg};

    // Read-only region decode for the candidate word address
    always_comb begin
        unique case (prot_mode)
            2'd0:    prot_hit = 1'b0;
            2'd1:    prot_hit = (waddr[ADDR_W-1 -: 2] == 2'b11);
            2'd2:    prot_hit = waddr[ADDR_W-1];
            default: prot_hit = 1'b1;
        endcase
    end

    // Bit shifting, byte decisions, acknowledge timing and commit request
    always_ff @(posedge clk) begin
        buf_we     <= 1'b0;
        buf_clr    <= 1'b0;
        commit_req <= 1'b0;
        if (!rst_n) begin
            ph       <= PH_IDLE;
            shreg    <= '0;
            bitcnt   <= '0;
            in_ack   <= 1'b0;
            ack_drv  <= 1'b0;
            ahi      <= '0;
            off      <= '0;
            page_idx <= '0;
            got_data <= 1'b0;
            buf_off  <= '0;
            buf_data <= '0;
        end else if (busy) begin
            ph      <= PH_IDLE;
            bitcnt  <= '0;
            in_ack  <= 1'b0;
            ack_drv <= 1'b0;
        end else if (start_evt) begin
            ph       <= PH_DEV;
            bitcnt   <= '0;
            in_ack   <= 1'b0;
            ack_drv  <= 1'b0;
            got_data <= 1'b0;
            buf_clr  <= 1'b1;
        end else if (stop_evt) begin
            commit_req <= (ph == PH_DATA) && got_data;
            ph         <= PH_IDLE;
            in_ack     <= 1'b0;
            ack_drv    <= 1'b0;
            got_data   <= 1'b0;
        end else if (scl_rise && !in_ack && bitcnt < 4'd8 &&
                     ph != PH_IDLE && ph != PH_SKIP) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall && in_ack) begin
            in_ack  <= 1'b0;
            ack_drv <= 1'b0;
            bitcnt  <= '0;
        end else if (scl_fall && bitcnt == 4'd8) begin
            in_ack <= 1'b1;
            unique case (ph)
                PH_DEV: begin
                    if (shreg[7:1] == DEV_ADDR && !shreg[0]) begin
                        ack_drv <= 1'b1;
                        ph      <= PH_AHI;
                    end else begin
                        ack_drv <= 1'b0;
                        ph      <= PH_SKIP;
                    end
                end
                PH_AHI: begin
                    ahi     <= shreg[HI_W-1:0];
                    ack_drv <= 1'b1;
                    ph      <= PH_ALO;
                end
                PH_ALO: begin
                    if (prot_hit) begin
                        ack_drv <= 1'b0;
                        ph      <= PH_SKIP;
                    end else begin
                        ack_drv  <= 1'b1;
                        off      <= waddr[OFF_W-1:0];
                        page_idx <= waddr[ADDR_W-1 -: PG_W];
                        ph       <= PH_DATA;
                    end
                end
                PH_DATA: begin
                    ack_drv  <= 1'b1;
                    buf_we   <= 1'b1;
                    buf_off  <= off;
                    buf_data <= shreg;
                    off      <= off + 1'b1;
                    got_data <= 1'b1;
                end
                default: ack_drv <= 1'b0;
            endcase
        end
    end

    assign sda_oe = ack_drv;
endmodule

// File: rtl/eewr_page_buf.sv
// Module: eewr_page_buf
// One-page staging buffer: a byte and a received flag per offset.
// Assumes: clr and we are never asserted in the same cycle for intent;
// clr wins.
module eewr_page_buf #(
    parameter int OFF_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     we,
    input  logic [OFF_W-1:0]         off,
    input  logic [7:0]               wdata,
    output logic [(1<<OFF_W)*8-1:0]  data_flat,
    output logic [(1<<OFF_W)-1:0]    valid
);
    localparam int PAGE = 1 << OFF_W;

    for (genvar i = 0; i < PAGE; i++) begin : g_slot
        logic [7:0] d_q;
        logic       v_q;
        // Capture the byte addressed to this offset, mark it received
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                d_q <= '0;
                v_q <= 1'b0;
            end else if (clr) begin
                v_q <= 1'b0;
            end else if (we && off == OFF_W'(i)) begin
                d_q <= wdata;
                v_q <= 1'b1;
            end
        end
        assign data_flat[i*8 +: 8] = d_q;
        assign valid[i]            = v_q;
    end
endmodule

// File: rtl/eewr_wcycle.sv
// Module: eewr_wcycle
// Write-cycle timer: busy for WR_CYCLES clocks after go, with a done
// pulse in the last busy cycle.
// Assumes: WR_CYCLES >= 2; go is ignored while busy.
module eewr_wcycle #(
    parameter int WR_CYCLES = 625000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy,
    output logic done
);
    localparam int             CW   = $clog2(WR_CYCLES + 1);
    localparam logic [CW-1:0]  LOAD = CW'(WR_CYCLES);

    logic [CW-1:0] cnt;

    // Load on go, count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (go && cnt == '0)
            cnt <= LOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));
endmodule

// File: rtl/eewr_array.sv
// Module: eewr_array
// Register-held byte array; on commit, every location of the selected
// page whose offset was received takes its staged byte.
// Assumes: the array depth is 2**ADDR_W and pages are 2**OFF_W bytes.
module eewr_array #(
    parameter int ADDR_W = 9,
    parameter int OFF_W  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit,
    input  logic [ADDR_W-OFF_W-1:0]  page,
    input  logic [(1<<OFF_W)*8-1:0]  data_flat,
    input  logic [(1<<OFF_W)-1:0]    valid,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE  = 1 << OFF_W;
    localparam int PG_W  = ADDR_W - OFF_W;

    logic [7:0] mem [DEPTH];

    // Parallel page commit, zero on reset
    always_ff @(posedge clk) begin
        for (int a = 0; a < DEPTH; a++) begin
            if (!rst_n)
                mem[a] <= '0;
            else if (commit && PG_W'(a / PAGE) == page && valid[a % PAGE])
                mem[a] <= data_flat[(a % PAGE)*8 +: 8];
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eewr_target.sv
// Module: eewr_target (top)
// Serial EEPROM write-path target: bus sampling, byte decoding with
// acknowledge, page staging, timed write cycle and array commit.
// Assumes: SCL and SDA are pulled up externally; sda_oe drives low only.
module eewr_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         ADDR_W      = 9,
    parameter int         OFF_W       = 6,
    parameter int         WR_CYCLES   = 625000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [1:0]        prot_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    localparam int PAGE = 1 << OFF_W;
    localparam int PG_W = ADDR_W - OFF_W;

    logic              sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic              buf_we, buf_clr, commit_req, wc_done;
    logic [OFF_W-1:0]  buf_off;
    logic [7:0]        buf_data;
    logic [PG_W-1:0]   page_idx;
    logic [PAGE*8-1:0] stage_flat;
    logic [PAGE-1:0]   stage_valid;

    eewr_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    eewr_proto #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DEV_ADDR(DEV_ADDR)) u_proto (
        .clk(clk), .rst_n(rst_n), .busy(busy), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt), .prot_mode(prot_mode),
        .sda_oe(sda_oe), .buf_we(buf_we), .buf_off(buf_off),
        .buf_data(buf_data), .buf_clr(buf_clr), .page_idx(page_idx),
        .commit_req(commit_req)
    );

    eewr_page_buf #(.OFF_W(OFF_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr || wc_done), .we(buf_we),
        .off(buf_off), .wdata(buf_data),
        .data_flat(stage_flat), .valid(stage_valid)
    );

    eewr_wcycle #(.WR_CYCLES(WR_CYCLES)) u_wcyc (
        .clk(clk), .rst_n(rst_n), .go(commit_req),
        .busy(busy), .done(wc_done)
    );

    eewr_array #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .commit(wc_done), .page(page_idx),
        .data_flat(stage_flat), .valid(stage_valid),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: rtl/eewr_target_chk.sv
// Module: eewr_target_chk
// Cycle-level properties of eewr_target, attached by bind below.
// Assumes: SCL low phases outlast the synchronizer delay.
module eewr_target_chk #(
    parameter int ADDR_W    = 9,
    parameter int WR_CYCLES = 625000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              busy,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic              wc_done,
    input logic              stop_evt
);
    int unsigned bcnt;

    // Count consecutive busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) bcnt <= 0;
        else                 bcnt <= bcnt + 1;
    end

    AST_BUSY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);                                           // R6
    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == WR_CYCLES));                        // R6
    AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt, 2));                         // R5
    AST_ARRAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(rd_addr) && !$past(wc_done)) |-> $stable(rd_data)); // R5
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_i);                // R9
endmodule

bind eewr_target eewr_target_chk #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .busy(busy),
    .rd_addr(rd_addr), .rd_data(rd_data), .wc_done(wc_done),
    .stop_evt(stop_evt)
);

// File: tb/eewr_target_tb_top.sv
// Bench for eewr_target: bit-level bus master, reference array model,
// directed corner cases plus seeded random page writes.
module eewr_target_tb_top;
    localparam int ADDR_W = 9;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WRC    = 400;
    localparam int H      = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] prot_mode = 2'd0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic sda_oe, busy;
    wire  sda_line = sda_m & ~sda_oe;

    int checks = 0, errors = 0;
    logic [7:0] exp_mem [DEPTH];
    logic [7:0] wdat [128];

    always #4 clk = ~clk;

    eewr_target #(.DEV_ADDR(7'h50), .ADDR_W(ADDR_W), .WR_CYCLES(WRC)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .prot_mode(prot_mode), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic hold();
        repeat (H) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(); scl_m = 1'b1; hold();
        sda_m = 1'b0; hold(); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(); scl_m = 1'b1; hold(); sda_m = 1'b1; hold();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; hold(); scl_m = 1'b1; hold(); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; hold(); scl_m = 1'b1;
        repeat (H/2) @(posedge clk);
        #1 ack = !sda_line;
        hold(); scl_m = 1'b0;
    endtask

    // Full write transaction; n data bytes taken from wdat
    task automatic xfer(input logic [7:0] devb, input logic [15:0] wa, input int n,
                        input bit do_stop, output bit a_dev, output bit a_hi,
                        output bit a_lo, output int n_ack);
        bit a;
        bus_start();
        send_byte(devb, a_dev);
        send_byte(wa[15:8], a_hi);
        send_byte(wa[7:0], a_lo);
        n_ack = 0;
        for (int i = 0; i < n; i++) begin
            send_byte(wdat[i], a);
            if (a) n_ack++;
        end
        if (do_stop) bus_stop();
    endtask

    // Reference: page-wrapping placement of n bytes
    function automatic void model_write(input logic [ADDR_W-1:0] wa, input int n);
        for (int i = 0; i < n; i++) begin
            logic [5:0] o;
            o = wa[5:0] + 6'(i);
            exp_mem[{wa[ADDR_W-1:6], o}] = wdat[i];
        end
    endfunction

    task automatic compare_mem(input string req);
        int bad = -1;
        logic [7:0] got = '0;
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = ADDR_W'(a); #1;
            if (rd_data !== exp_mem[a] && bad < 0) begin
                bad = a; got = rd_data;
            end
        end
        chk(bad < 0, req, got, (bad < 0) ? 0 : exp_mem[bad]);
        if (bad >= 0) $display("  first mismatch at address %0h", bad);
    endtask

    task automatic wait_idle();
        while (busy) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic fill(input int n, input int seed_base);
        for (int i = 0; i < n; i++) wdat[i] = 8'(seed_base + i * 7 + 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit ad, ah, al, a2;
        int na;
        void'($urandom(32'd4242));
        for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'h00;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        chk(sda_oe == 1'b0, "R9 sda_oe after reset", sda_oe, 0);
        chk(busy == 1'b0, "R9 busy after reset", busy, 0);
        compare_mem("R9 array zero after reset");

        // R1 wrong device code and read bit set
        fill(2, 8'h10);
        xfer(8'hA2, 16'h0010, 2, 1, ad, ah, al, na);
        chk(!ad && !ah && !al && na == 0, "R1 foreign device refused", {ad, ah, al}, 0);
        repeat (4) @(posedge clk); #1;
        chk(!busy, "R1 no write cycle for foreign device", busy, 0);
        xfer(8'hA1, 16'h0010, 2, 1, ad, ah, al, na);
        chk(!ad && na == 0, "R1 read bit refused", ad, 0);
        compare_mem("R1 array untouched");

        // R2 R3 single byte write; R5 R6 busy window
        wdat[0] = 8'h3C;
        xfer(8'hA0, 16'h0005, 1, 1, ad, ah, al, na);
        chk(ad && ah && al && na == 1, "R2 address bytes and data acked", {ad, ah, al}, 7);
        repeat (4) @(posedge clk); #1;
        chk(busy, "R6 busy after STOP", busy, 1);
        bus_start();
        send_byte(8'hA0, a2);
        bus_stop();
        chk(!a2 && busy, "R6 device byte ignored while busy", a2, 0);
        compare_mem("R5 array unchanged during write cycle");
        wait_idle();
        model_write(9'h005, 1);
        compare_mem("R3 single byte committed");

        // R2 upper address bits ignored; R3 wrap from offset 60 with 12 bytes
        fill(12, 8'h40);
        xfer(8'hA0, 16'hFEBC, 12, 1, ad, ah, al, na);
        chk(na == 12, "R3 all page bytes acked", na, 12);
        wait_idle();
        model_write(9'h0BC, 12);
        compare_mem("R3 wrap within page at offset 60");

        // R4 more than one page of data
        fill(70, 8'h80);
        xfer(8'hA0, 16'h0140, 70, 1, ad, ah, al, na);
        wait_idle();
        model_write(9'h140, 70);
        compare_mem("R4 overwrite after 64 bytes");

        // R7 protection modes
        prot_mode = 2'd1;
        fill(3, 8'h20);
        xfer(8'hA0, 16'h01C0, 3, 1, ad, ah, al, na);
        chk(ad && ah && !al && na == 0, "R7 mode1 upper quarter refused", {ad, ah, al}, 6);
        repeat (4) @(posedge clk); #1;
        chk(!busy, "R7 no write cycle when protected", busy, 0);
        prot_mode = 2'd2;
        xfer(8'hA0, 16'h0100, 3, 1, ad, ah, al, na);
        chk(!al && na == 0, "R7 mode2 upper half refused", al, 0);
        xfer(8'hA0, 16'h00C2, 3, 1, ad, ah, al, na);
        chk(al && na == 3, "R7 mode2 lower half accepted", al, 1);
        wait_idle();
        model_write(9'h0C2, 3);
        prot_mode = 2'd3;
        xfer(8'hA0, 16'h0000, 3, 1, ad, ah, al, na);
        chk(!al, "R7 mode3 whole array refused", al, 0);
        compare_mem("R7 protected locations kept");
        prot_mode = 2'd0;

        // R8 abort by repeated START mid-byte, then fresh transaction
        fill(2, 8'h55);
        xfer(8'hA0, 16'h0020, 2, 0, ad, ah, al, na);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        fill(1, 8'h66);
        xfer(8'hA0, 16'h0030, 1, 1, ad, ah, al, na);
        chk(ad && na == 1, "R8 fresh transaction after repeated START", ad, 1);
        wait_idle();
        model_write(9'h030, 1);
        compare_mem("R8 aborted data discarded");

        // R10 address only, no data
        xfer(8'hA0, 16'h0005, 0, 1, ad, ah, al, na);
        repeat (4) @(posedge clk); #1;
        chk(!busy, "R10 no write cycle without data", busy, 0);
        compare_mem("R10 array unchanged");

        // R3 R5 seeded random page writes
        for (int t = 0; t < 5; t++) begin
            int n;
            logic [ADDR_W-1:0] wa;
            n  = 1 + int'($urandom_range(19));
            wa = ADDR_W'($urandom_range(DEPTH - 1));
            for (int i = 0; i < n; i++) wdat[i] = 8'($urandom);
            xfer(8'hA0, {7'h00, wa}, n, 1, ad, ah, al, na);
            chk(na == n, "R3 random data acked", na, n);
            wait_idle();
            model_write(wa, n);
            compare_mem("R5 random write committed");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule